// File: doc/BRIEF.md
# Peripheral Chip-Select Region Decoder

This block turns bus addresses into a bank of active-low peripheral chip selects. A programmable base address marks the start of a peripheral window. The window is cut into equal 256-byte regions, and region n drives select n. A configuration bit places the window in either I/O space or memory space. A select only fires for bus cycles of that space, and only while the address-phase strobe is high. The decode is registered, so each select changes one clock after the address phase is presented.

The DRAM bank decoder of the system may claim the same address. In that case the peripheral region wins. The block raises a suppression output that blocks the DRAM access. The block also reports the wait-state count of the winning target: the per-region setting when a select fires, and otherwise the DRAM bank setting. If a peripheral region overlaps DRAM with fewer wait states than the DRAM bank, the block raises a configuration-error flag.

Top module: `pcs_decoder`

## Requirements
- R1: While rst_ni is low, all selects are high (inactive), and dram_inhibit_o, cfg_err_o and wait_count_o are all zero.
- R2: Take a clock edge where addr_phase_i is 1, io_cycle_i equals space_io_i, and base_i <= addr_i <= base_i + 1535. After that edge, sel_no[(addr_i - base_i) >> 8] is 0 and every other select is 1.
- R3: An address below base_i, or at or above base_i + 1536, drives no select low after the edge.
- R4: When io_cycle_i differs from space_io_i (1 = I/O cycle or I/O-mapped window, 0 = memory), no select goes low.
- R5: When addr_phase_i is 0 at an edge, all selects are high after that edge.
- R6: At most one select is low in any cycle.
- R7: dram_inhibit_o is 1 after an edge exactly when a select asserts at that edge and dram_hit_i was 1. Otherwise it is 0.
- R8: When select n asserts, wait_count_o equals field n of region_wait_i (bits n*4+3 down to n*4). When no select asserts, wait_count_o equals dram_wait_i. Both values are registered at the same edge as the selects.
- R9: cfg_err_o is 1 after an edge exactly when dram_inhibit_o becomes 1 at that edge and the winning region's wait field is less than dram_wait_i.
- R10: The window does not wrap past the top of the 20-bit address space. With base_i near the top, low addresses select nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 20 | Bus address |
| io_cycle_i | input | 1 | 1 for an I/O cycle, 0 for a memory cycle |
| addr_phase_i | input | 1 | Multiplexed address-phase strobe |
| base_i | input | 20 | Base address of the peripheral window |
| space_io_i | input | 1 | 1 maps the window to I/O space, 0 to memory |
| region_wait_i | input | 24 | Per-region wait counts, 4 bits per region, region 0 in the low bits |
| dram_hit_i | input | 1 | DRAM bank decode hit for the current address |
| dram_wait_i | input | 4 | Wait count of the DRAM bank |
| sel_no | output | 6 | Active-low peripheral selects |
| dram_inhibit_o | output | 1 | Suppresses the DRAM access |
| wait_count_o | output | 4 | Effective wait count |
| cfg_err_o | output | 1 | Overlap with too few wait states |

## Verification
On every cycle, the assertions check that at most one select is active. They also check that:
- suppression and the configuration error only appear together with an active select;
- an active select always follows a strobed cycle of the configured space;
- an idle decode reports the DRAM wait count.

Other behaviour can only be shown by the bench's reference model, which runs against directed and random address patterns. This covers which select index goes with an address, the exact window edges at base and base+1535, the per-region wait mapping, and the top-of-space wrap case.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  typedef enum logic {
    SPACE_MEM = 1'b0,
    SPACE_IO  = 1'b1
  } space_e;

  localparam int unsigned REGION_SHIFT_DEF = 8;
endpackage

// File: rtl/pcs_range_match.sv
module pcs_range_match #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned N_SEL  = 6,
  parameter int unsigned SHIFT  = pcs_pkg::REGION_SHIFT_DEF,
  localparam int unsigned IDX_W = (N_SEL > 1) ? $clog2(N_SEL) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              strobe_i,
  input  logic              io_cycle_i,
  input  logic              space_io_i,
  output logic [N_SEL-1:0]  sel_vec_o
);
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(N_SEL) << SHIFT;

  logic [ADDR_W:0]   diff;
  logic              borrow;
  logic [ADDR_W-1:0] offs;
  logic              in_win;
  logic              space_ok;
  logic              hit;
  logic [IDX_W-1:0]  idx;

  assign diff     = {1'b0, addr_i} - {1'b0, base_i};
  assign borrow   = diff[ADDR_W];
  assign offs     = diff[ADDR_W-1:0];
  assign in_win   = !borrow && ({1'b0, offs} < LIMIT);
  assign space_ok = (pcs_pkg::space_e'(io_cycle_i) == pcs_pkg::space_e'(space_io_i));
  assign hit      = strobe_i && space_ok && in_win;
  assign idx      = offs[SHIFT +: IDX_W];

  for (genvar i = 0; i < N_SEL; i++) begin : g_sel
    assign sel_vec_o[i] = hit && (idx == IDX_W'(i));
  end
endmodule

// File: rtl/pcs_wait_sel.sv
module pcs_wait_sel #(
  parameter int unsigned N_SEL  = 6,
  parameter int unsigned WAIT_W = 4
) (
  input  logic [N_SEL-1:0]        sel_vec_i,
  input  logic [N_SEL*WAIT_W-1:0] region_wait_i,
  input  logic                    dram_hit_i,
  input  logic [WAIT_W-1:0]       dram_wait_i,
  output logic [WAIT_W-1:0]       wait_o,
  output logic                    inhibit_o,
  output logic                    err_o
);
  logic [WAIT_W-1:0] region_w;
  logic              any_sel;

  always_comb begin
    region_w = '0;
    for (int i = 0; i < int'(N_SEL); i++) begin
      region_w |= {WAIT_W{sel_vec_i[i]}} & region_wait_i[i*WAIT_W +: WAIT_W];
    end
  end

  assign any_sel   = |sel_vec_i;
  assign wait_o    = any_sel ? region_w : dram_wait_i;
  assign inhibit_o = any_sel && dram_hit_i;
  // overlapping region must wait at least as long as the DRAM bank
  assign err_o     = inhibit_o && (region_w < dram_wait_i);
endmodule

// File: rtl/pcs_decoder.sv
module pcs_decoder #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned N_SEL  = 6,
  parameter int unsigned WAIT_W = 4,
  parameter int unsigned SHIFT  = pcs_pkg::REGION_SHIFT_DEF
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    io_cycle_i,
  input  logic                    addr_phase_i,
  input  logic [ADDR_W-1:0]       base_i,
  input  logic                    space_io_i,
  input  logic [N_SEL*WAIT_W-1:0] region_wait_i,
  input  logic                    dram_hit_i,
  input  logic [WAIT_W-1:0]       dram_wait_i,
  output logic [N_SEL-1:0]        sel_no,
  output logic                    dram_inhibit_o,
  output logic [WAIT_W-1:0]       wait_count_o,
  output logic                    cfg_err_o
);
  logic [N_SEL-1:0]  sel_vec;
  logic [WAIT_W-1:0] wait_nxt;
  logic              inhibit_nxt;
  logic              err_nxt;
  logic              live_q;

  pcs_range_match #(
    .ADDR_W(ADDR_W), .N_SEL(N_SEL), .SHIFT(SHIFT)
  ) u_match (
    .addr_i     (addr_i),
    .base_i     (base_i),
    .strobe_i   (addr_phase_i),
    .io_cycle_i (io_cycle_i),
    .space_io_i (space_io_i),
    .sel_vec_o  (sel_vec)
  );

  pcs_wait_sel #(
    .N_SEL(N_SEL), .WAIT_W(WAIT_W)
  ) u_wait (
    .sel_vec_i     (sel_vec),
    .region_wait_i (region_wait_i),
    .dram_hit_i    (dram_hit_i),
    .dram_wait_i   (dram_wait_i),
    .wait_o        (wait_nxt),
    .inhibit_o     (inhibit_nxt),
    .err_o         (err_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_no         <= '1;
      dram_inhibit_o <= 1'b0;
      wait_count_o   <= '0;
      cfg_err_o      <= 1'b0;
      live_q         <= 1'b0;
    end else begin
      sel_no         <= ~sel_vec;
      dram_inhibit_o <= inhibit_nxt;
      wait_count_o   <= wait_nxt;
      cfg_err_o      <= err_nxt;
      live_q         <= 1'b1;
    end
  end

  a_r6_one_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~sel_no));

  a_r7_inhibit_needs_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dram_inhibit_o |-> (sel_no != '1));

  a_r9_err_needs_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> dram_inhibit_o);

  a_r5_no_strobe_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_phase_i |=> (sel_no == '1));

  a_r4_space_match: assert property (@(posedge clk_i) disable iff (!rst_ni || !live_q)
    (sel_no != '1) |-> $past(io_cycle_i == space_io_i && addr_phase_i));

  a_r8_idle_dram_wait: assert property (@(posedge clk_i) disable iff (!rst_ni || !live_q)
    (sel_no == '1) |-> (wait_count_o == $past(dram_wait_i)));
endmodule

// File: tb/pcs_decoder_tb.sv
module pcs_decoder_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [19:0] addr_i = '0;
  logic        io_cycle_i = 1'b0;
  logic        addr_phase_i = 1'b0;
  logic [19:0] base_i = '0;
  logic        space_io_i = 1'b0;
  logic [23:0] region_wait_i = '0;
  logic        dram_hit_i = 1'b0;
  logic [3:0]  dram_wait_i = '0;
  logic [5:0]  sel_no;
  logic        dram_inhibit_o;
  logic [3:0]  wait_count_o;
  logic        cfg_err_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  pcs_decoder u_dut (
    .clk_i, .rst_ni, .addr_i, .io_cycle_i, .addr_phase_i, .base_i,
    .space_io_i, .region_wait_i, .dram_hit_i, .dram_wait_i,
    .sel_no, .dram_inhibit_o, .wait_count_o, .cfg_err_o
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // behavioural reference: inputs driven now, outputs compared one edge later
  task automatic step(string tag, int addr, bit io, bit strobe, int base, bit sp,
                      bit dh, int dw);
    int e_sel, e_wait, idx, rw;
    bit e_inh, e_err, hit;
    @(negedge clk_i);
    addr_i = 20'(addr); io_cycle_i = io; addr_phase_i = strobe; base_i = 20'(base);
    space_io_i = sp; dram_hit_i = dh; dram_wait_i = 4'(dw);
    hit = strobe && (io == sp) && (addr >= base) && (addr - base < 6 * 256);
    idx = hit ? (addr - base) / 256 : 0;
    rw = (region_wait_i >> (idx * 4)) & 15;
    e_sel = hit ? (63 & ~(1 << idx)) : 63;
    e_inh = hit && dh;
    e_wait = hit ? rw : dw;
    e_err = e_inh && (rw < dw);
    @(negedge clk_i);
    chk(tag, "sel_no", int'(sel_no), e_sel);
    chk(tag, "dram_inhibit_o", int'(dram_inhibit_o), int'(e_inh));
    chk(tag, "wait_count_o", int'(wait_count_o), e_wait);
    chk(tag, "cfg_err_o", int'(cfg_err_o), int'(e_err));
    chk("R6", "select count", $countones(~sel_no) <= 1 ? 1 : 0, 1);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    region_wait_i = 24'h5A3C71;  // regions 0..5: 1,7,C,3,A,5
    dram_wait_i = 4'h6;
    addr_phase_i = 1'b1;
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk("R1", "sel_no", int'(sel_no), 63);
    chk("R1", "dram_inhibit_o", int'(dram_inhibit_o), 0);
    chk("R1", "wait_count_o", int'(wait_count_o), 0);
    chk("R1", "cfg_err_o", int'(cfg_err_o), 0);
    rst_ni = 1'b1;

    // R2/R8: both edges of every region, memory window
    for (int r = 0; r < 6; r++) begin
      step("R2", 'h40000 + r * 256, 0, 1, 'h40000, 0, 0, 6);
      step("R8", 'h40000 + r * 256 + 255, 0, 1, 'h40000, 0, 0, 9);
    end
    // R2: unaligned base, I/O window
    step("R2", 'h01234 + 700, 1, 1, 'h01234, 1, 0, 2);
    // R3: just outside both ends
    step("R3", 'h3FFFF, 0, 1, 'h40000, 0, 0, 4);
    step("R3", 'h40000 + 1536, 0, 1, 'h40000, 0, 0, 4);
    // R4: space mismatch both ways
    step("R4", 'h40100, 1, 1, 'h40000, 0, 0, 3);
    step("R4", 'h40100, 0, 1, 'h40000, 1, 0, 3);
    // R5: no strobe
    step("R5", 'h40100, 0, 0, 'h40000, 0, 1, 3);
    // R7/R9: overlap, region 0 wait 1 < 6 -> error
    step("R9", 'h40010, 0, 1, 'h40000, 0, 1, 6);
    // R7: overlap, region 2 wait C >= 6 -> no error; equal case region 3 wait 3
    step("R7", 'h40210, 0, 1, 'h40000, 0, 1, 6);
    step("R9", 'h40310, 0, 1, 'h40000, 0, 1, 3);
    // R7: DRAM hit but no select
    step("R7", 'h50000, 0, 1, 'h40000, 0, 1, 5);
    // R10: top of space, no wrap
    step("R10", 'hFFF80, 0, 1, 'hFFF00, 0, 0, 1);
    step("R10", 'h00010, 0, 1, 'hFFF00, 0, 0, 1);
    step("R10", 'h000FF, 0, 1, 'hFFF00, 0, 0, 1);

    // random patterns around the window
    for (int n = 0; n < 3000; n++) begin
      int b, a;
      b = (n % 7 == 0) ? 'hFFE00 : int'($urandom_range(0, 'hFF000));
      a = (b + int'($urandom_range(0, 2047)) - 256) & 'hFFFFF;
      if (n % 50 == 0) region_wait_i = 24'($urandom);
      step("R2", a, 1'($urandom), ($urandom_range(0, 7) != 0), b,
           1'($urandom), 1'($urandom), int'($urandom_range(0, 15)));
    end

    // R1: async reset clears outputs mid-traffic
    step("R2", 'h40110, 0, 1, 'h40000, 0, 1, 15);
    #1 rst_ni = 1'b0;
    #1;
    chk("R1", "sel_no", int'(sel_no), 63);
    chk("R1", "wait_count_o", int'(wait_count_o), 0);
    chk("R1", "cfg_err_o", int'(cfg_err_o), 0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule